// File: doc/BRIEF.md
# PHY Management Serial Command Controller

This block lets software read and write PHY registers over the two-wire management interface (a clock pin and a bidirectional data pin). Software first places a 16-bit value in a data register when it wants a write. It then writes one command word holding the PHY address, the register number and a write flag. That command write starts a serial frame. A busy flag in the same command word stays set while the frame is in progress and clears itself at the end. After a read, software polls busy until it clears and then fetches the returned value from the data register.

The management clock comes from a programmable divider on the system clock. It is held low whenever no frame is in progress. Each frame has 64 bit periods. The controller drives the data pin on the falling side of the management clock and samples it at the rising edge. On reads it releases the pin from the turnaround onward, so the PHY can answer.

Top module: `mii_mgmt_ctrl`

## Requirements
- R1: The command word (reg_sel = 0) holds the PHY address in bits 15:11, the register number in bits 10:6 and the write flag in bit 1 (1 = write, 0 = read). Reading it back returns these fields with busy in bit 0. All other bits read 0, and any value written to them is ignored.
- R2: A command written while idle sets busy (command bit 0) from the next cycle. Busy stays set for exactly 64 × 2 × MDC_HALF_CYCLES clock cycles and then clears itself.
- R3: A write to the data register (reg_sel = 1) stores bits 15:0 of the written value, and the data register reads these bits back with bits 31:16 at 0. A write frame sends the value the data register held when the command was accepted.
- R4: Every frame begins with 32 ones, then start bits 0,1, then opcode 1,0 for a read or 0,1 for a write, then the 5-bit PHY address and the 5-bit register number, each most significant bit first. All of these bits are driven.
- R5: In a write frame the controller drives turnaround bits 1,0 and then the 16 data bits, most significant bit first.
- R6: In a read frame mdio_oe is low from the first turnaround bit to the end of the frame. The controller samples 16 bits, most significant first, one at each rising MDC edge of the data bits. When busy clears, the data register holds those 16 bits in bits 15:0.
- R7: Each bit period is MDC_HALF_CYCLES clock cycles with mdc low followed by MDC_HALF_CYCLES cycles with mdc high. mdio_o changes only while mdc is low.
- R8: A command write made while busy is set is ignored. The command fields do not change, the running frame is not disturbed, and no further frame follows it.
- R9: After reset, and whenever no frame is in progress, mdc and mdio_oe are low. After reset both registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | Register select: 0 command word, 1 data register |
| reg_wdata | input | 32 | Value for the register write |
| cmd_rdata | output | 32 | Current command word including busy |
| data_rdata | output | 32 | Current data register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
A wrong bit index or phase count inside the frame sequencer shows up on mdc, mdio_o or mdio_oe within one bit period, because the bench compares all three against a behavioural model on every cycle. A fault in the divider moves an mdc edge by at least one cycle, and that mismatch appears on the very next compare. A fault in the capture path or in the command register bookkeeping only shows up on data_rdata or cmd_rdata. For a capture fault that is the cycle busy clears; for the command register it is the cycle after the ignored or accepted write. The bench compares these registers every cycle, so either fault is reported without waiting for a later frame.

// File: rtl/mii_mgmt_pkg.sv
// Package: shared field positions and frame layout for the PHY
// management controller.
// Assumes clause-22 style frames of fixed 64-bit length.
package mii_mgmt_pkg;

    localparam int REG_W    = 32;
    localparam int FIELD_W  = 5;
    localparam int DATA_W   = 16;
    localparam int PHY_LSB  = 11;
    localparam int REG_LSB  = 6;
    localparam int WR_BIT   = 1;
    localparam int BUSY_BIT = 0;

    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * FIELD_W + 2 + DATA_W;
    localparam int TA_IDX    = PRE_LEN + 4 + 2 * FIELD_W;
    localparam int DATA_IDX  = TA_IDX + 2;

    localparam logic [1:0] START_BITS = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] TA_DRIVE   = 2'b10;

    typedef enum logic {SEL_CMD = 1'b0, SEL_DATA = 1'b1} reg_sel_e;

    // Assemble the whole serial frame, first bit in the top position.
    function automatic logic [FRAME_LEN-1:0] build_frame(
        input logic               wr,
        input logic [FIELD_W-1:0] phy,
        input logic [FIELD_W-1:0] regad,
        input logic [DATA_W-1:0]  data
    );
        return {{PRE_LEN{1'b1}}, START_BITS, (wr ? OP_WRITE : OP_READ),
                phy, regad, TA_DRIVE, (wr ? data : {DATA_W{1'b1}})};
    endfunction

endpackage

// File: rtl/mii_mdc_timer.sv
// Module: management clock divider.
// Produces mdc while run is high: HALF_CYCLES low, then HALF_CYCLES high
// per bit period. Flags the cycle before the rising edge (sample point)
// and the last cycle of each bit period. Assumes HALF_CYCLES >= 1.
module mii_mdc_timer #(
    parameter int HALF_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic sample_tick,
    output logic bit_end
);
    localparam int PERIOD = 2 * HALF_CYCLES;
    localparam int CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] PRE_RISE = CNT_W'(HALF_CYCLES - 1);
    localparam logic [CNT_W-1:0] HIGH_PH = CNT_W'(HALF_CYCLES);

    logic [CNT_W-1:0] phase_q;

    // Phase counter: wraps every bit period, parked at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || phase_q == LAST_PH) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + CNT_W'(1);
        end
    end

    assign mdc         = run && (phase_q >= HIGH_PH);
    assign sample_tick = run && (phase_q == PRE_RISE);
    assign bit_end     = run && (phase_q == LAST_PH);

    // R7: the sample point is always followed by an mdc rising edge.
    p_sample_at_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> $rose(mdc));

    // R7: a bit period ends with mdc low in the next cycle.
    p_bit_end_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> !mdc);

endmodule

// File: rtl/mii_frame_seq.sv
// Module: serial frame sequencer.
// Loads a complete frame on start and shifts one bit out per bit
// period. Releases the data pin from turnaround on reads and captures
// the 16 data bits at the sample points. Assumes start is only pulsed
// while idle; a start while active is ignored.
module mii_frame_seq
    import mii_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_wr,
    input  logic [FIELD_W-1:0] start_phy,
    input  logic [FIELD_W-1:0] start_reg,
    input  logic [DATA_W-1:0]  start_data,
    input  logic               sample_tick,
    input  logic               bit_end,
    input  logic               mdio_i,
    output logic               active,
    output logic               done,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(TA_IDX);
    localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(DATA_IDX);

    logic [FRAME_LEN-1:0] frame_q;
    logic [IDX_W-1:0]     bit_idx_q;
    logic                 wr_q;
    logic                 active_q;
    logic [DATA_W-1:0]    cap_q;
    logic                 last_bit;
    logic                 capture;

    assign last_bit = (bit_idx_q == LAST_IDX);
    assign capture  = active_q && sample_tick && (bit_idx_q >= DATA_POS);
    assign done     = active_q && bit_end && last_bit;
    assign active   = active_q;
    assign mdio_o   = active_q ? frame_q[FRAME_LEN-1] : 1'b1;
    assign mdio_oe  = active_q && (wr_q || bit_idx_q < TA_POS);
    assign rd_data  = cap_q;

    // Frame state: load on start, advance one bit per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            wr_q      <= 1'b0;
            bit_idx_q <= '0;
            frame_q   <= '1;
        end else if (start && !active_q) begin
            active_q  <= 1'b1;
            wr_q      <= start_wr;
            bit_idx_q <= '0;
            frame_q   <= build_frame(start_wr, start_phy, start_reg, start_data);
        end else if (active_q && bit_end) begin
            if (last_bit) begin
                active_q <= 1'b0;
            end else begin
                bit_idx_q <= bit_idx_q + IDX_W'(1);
            end
            frame_q <= {frame_q[FRAME_LEN-2:0], 1'b1};
        end
    end

    // Capture shifter: one input bit per data-bit sample point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (capture) begin
            cap_q <= {cap_q[DATA_W-2:0], mdio_i};
        end
    end

    // Checker counter: data samples taken in the current frame.
    logic [5:0] smp_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_cnt_q <= '0;
        end else if (start && !active_q) begin
            smp_cnt_q <= '0;
        end else if (capture) begin
            smp_cnt_q <= smp_cnt_q + 6'd1;
        end
    end

    // R6: a frame completes only after exactly 16 data samples.
    p_sixteen_samples_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> smp_cnt_q == 6'(DATA_W));

    // R4: the first bit put on the pin after a start is a preamble one.
    p_preamble_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active_q) |=> (mdio_o && mdio_oe));

endmodule

// File: rtl/mii_mgmt_ctrl.sv
// Module: PHY management command controller (top).
// Holds the command word and data register and starts a frame when a
// command is written while idle. Busy is the frame-active state and
// clears itself; read data lands in the data register on completion.
// Assumes a single write strobe with one register select bit.
module mii_mgmt_ctrl
    import mii_mgmt_pkg::*;
#(
    parameter int MDC_HALF_CYCLES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] cmd_rdata,
    output logic [31:0] data_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int FRAME_CYCLES = 2 * MDC_HALF_CYCLES * FRAME_LEN;

    logic [FIELD_W-1:0] cmd_phy_q;
    logic [FIELD_W-1:0] cmd_reg_q;
    logic               cmd_wr_q;
    logic [DATA_W-1:0]  data_q;
    logic               busy;
    logic               done;
    logic               cmd_write;
    logic               cmd_accept;
    logic               sample_tick;
    logic               bit_end;
    logic [DATA_W-1:0]  rd_data;

    assign cmd_write  = reg_wr && (reg_sel == SEL_CMD);
    assign cmd_accept = cmd_write && !busy;

    // Command fields: captured only when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_phy_q <= '0;
            cmd_reg_q <= '0;
            cmd_wr_q  <= 1'b0;
        end else if (cmd_accept) begin
            cmd_phy_q <= reg_wdata[PHY_LSB +: FIELD_W];
            cmd_reg_q <= reg_wdata[REG_LSB +: FIELD_W];
            cmd_wr_q  <= reg_wdata[WR_BIT];
        end
    end

    // Data register: software write, overridden by completed read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            if (reg_wr && reg_sel == SEL_DATA) begin
                data_q <= reg_wdata[DATA_W-1:0];
            end
            if (done && !cmd_wr_q) begin
                data_q <= rd_data;
            end
        end
    end

    // Read-back views of both registers.
    always_comb begin
        cmd_rdata = '0;
        cmd_rdata[PHY_LSB +: FIELD_W] = cmd_phy_q;
        cmd_rdata[REG_LSB +: FIELD_W] = cmd_reg_q;
        cmd_rdata[WR_BIT]             = cmd_wr_q;
        cmd_rdata[BUSY_BIT]           = busy;
        data_rdata                    = '0;
        data_rdata[DATA_W-1:0]        = data_q;
    end

    mii_mdc_timer #(
        .HALF_CYCLES (MDC_HALF_CYCLES)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (busy),
        .mdc         (mdc),
        .sample_tick (sample_tick),
        .bit_end     (bit_end)
    );

    mii_frame_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cmd_accept),
        .start_wr    (reg_wdata[WR_BIT]),
        .start_phy   (reg_wdata[PHY_LSB +: FIELD_W]),
        .start_reg   (reg_wdata[REG_LSB +: FIELD_W]),
        .start_data  (data_q),
        .sample_tick (sample_tick),
        .bit_end     (bit_end),
        .mdio_i      (mdio_i),
        .active      (busy),
        .done        (done),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .rd_data     (rd_data)
    );

    // Checker counter: length of the current busy window.
    logic [31:0] busy_cycles_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cycles_q <= '0;
        end else if (busy) begin
            busy_cycles_q <= busy_cycles_q + 32'd1;
        end else begin
            busy_cycles_q <= '0;
        end
    end

    // R2: busy lasts exactly one full frame.
    p_busy_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_cycles_q == 32'(FRAME_CYCLES));

    // R2: an accepted command raises busy.
    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> busy);

    // R8: a command written while busy leaves the fields untouched.
    p_cmd_ignored_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write && busy) |=> ($stable(cmd_phy_q) && $stable(cmd_reg_q) && $stable(cmd_wr_q)));

    // R7: the data pin changes only while mdc is low.
    p_mdio_moves_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc);

    // R9: nothing is driven on the bus while idle.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

endmodule

// File: tb/mii_mgmt_ctrl_tb.sv
// Bench: behavioural model of the command controller compared on every
// clock, plus directed checks and a PHY responder for read data.
module mii_mgmt_ctrl_tb_top;
    localparam int HALF      = 2;
    localparam int BITP      = 2 * HALF;
    localparam int FRAME_CYC = 64 * BITP;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic        reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] cmd_rdata;
    logic [31:0] data_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    always #5 clk = ~clk;

    mii_mgmt_ctrl #(.MDC_HALF_CYCLES(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state.
    bit          m_busy;
    int          m_t;
    logic [4:0]  m_phy;
    logic [4:0]  m_reg;
    bit          m_wr;
    logic [15:0] m_data;
    logic [15:0] m_fdata;
    logic [15:0] m_cap;
    logic [15:0] resp;
    bit          old_busy;
    bit          done_now;
    bit          done_rd;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input int b);
        if (b < 32)       return 1'b1;
        else if (b == 32) return 1'b0;
        else if (b == 33) return 1'b1;
        else if (b == 34) return m_wr ? 1'b0 : 1'b1;
        else if (b == 35) return m_wr ? 1'b1 : 1'b0;
        else if (b < 41)  return m_phy[40 - b];
        else if (b < 46)  return m_reg[45 - b];
        else if (b == 46) return 1'b1;
        else if (b == 47) return 1'b0;
        else              return m_fdata[63 - b];
    endfunction

    // Model update at each rising clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_phy = '0; m_reg = '0; m_wr = 0;
            m_data = '0; m_fdata = '0; m_cap = '0;
        end else begin
            old_busy = m_busy;
            done_now = 0;
            done_rd  = 0;
            if (m_busy) begin
                if ((m_t % BITP) == HALF - 1 && (m_t / BITP) >= 48)
                    m_cap = {m_cap[14:0], mdio_i};
                if (m_t == FRAME_CYC - 1) begin
                    m_busy = 0; done_now = 1; done_rd = !m_wr;
                end else begin
                    m_t++;
                end
            end
            if (reg_wr && reg_sel) m_data = reg_wdata[15:0];
            if (done_rd) m_data = m_cap;
            if (reg_wr && !reg_sel && !old_busy) begin
                m_busy  = 1;
                m_t     = 0;
                m_phy   = reg_wdata[15:11];
                m_reg   = reg_wdata[10:6];
                m_wr    = reg_wdata[1];
                m_fdata = m_data;
            end
        end
    end

    // Per-cycle comparison and PHY responder, away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            int bi;
            int ph;
            bi = m_t / BITP;
            ph = m_t % BITP;
            check("R7", "mdc", {31'b0, mdc}, {31'b0, m_busy && ph >= HALF});
            check(m_wr ? "R5" : "R6", "mdio_oe", {31'b0, mdio_oe},
                  {31'b0, m_busy && (m_wr || bi < 46)});
            if (m_busy && (m_wr || bi < 46))
                check(bi < 46 ? "R4" : "R5", "mdio_o", {31'b0, mdio_o}, {31'b0, exp_bit(bi)});
            check("R1,R2", "cmd_rdata", cmd_rdata,
                  {16'b0, m_phy, m_reg, 4'b0, m_wr, m_busy});
            check("R3,R6", "data_rdata", data_rdata, {16'b0, m_data});
            if (m_busy && bi >= 48) mdio_i = resp[63 - bi];
            else                    mdio_i = 1'b1;
        end else begin
            mdio_i = 1'b1;
        end
    end

    task automatic wr_reg(input logic sel, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    function automatic logic [31:0] cmd(input logic [4:0] p, input logic [4:0] r, input logic w);
        return (32'(p) << 11) | (32'(r) << 6) | (32'(w) << 1);
    endfunction

    task automatic wait_idle();
        while (cmd_rdata[0] !== 1'b0) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0; resp = '0;
        repeat (3) @(negedge clk);
        // R9: reset state.
        check("R9", "cmd_rdata reset", cmd_rdata, 32'h0);
        check("R9", "data_rdata reset", data_rdata, 32'h0);
        check("R9", "mdc reset", {31'b0, mdc}, 32'h0);
        check("R9", "mdio_oe reset", {31'b0, mdio_oe}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: data staging, upper bits ignored.
        wr_reg(1'b1, 32'h1234_A5C3);
        check("R3", "data staged", data_rdata, 32'h0000_A5C3);
        // R1, R2: write command with junk in undefined bits and bit 0.
        wr_reg(1'b0, cmd(5'h11, 5'h05, 1'b1) | 32'hFFFF_003D);
        check("R1", "write cmd fields", cmd_rdata, {16'b0, 5'h11, 5'h05, 4'b0, 1'b1, 1'b1});
        wait_idle();
        check("R2", "busy cleared after write", cmd_rdata, {16'b0, 5'h11, 5'h05, 4'b0, 1'b1, 1'b0});
        check("R3", "data kept after write", data_rdata, 32'h0000_A5C3);

        // R6: read, all-ones addresses.
        resp = 16'hBEEF;
        wr_reg(1'b0, cmd(5'h1F, 5'h1F, 1'b0));
        wait_idle();
        check("R6", "read data BEEF", data_rdata, 32'h0000_BEEF);

        // R8: command while busy is ignored.
        resp = 16'h8001;
        wr_reg(1'b0, cmd(5'h02, 5'h10, 1'b0));
        repeat (20) @(negedge clk);
        wr_reg(1'b0, cmd(5'h07, 5'h03, 1'b1));
        check("R8", "fields after ignored cmd", cmd_rdata, {16'b0, 5'h02, 5'h10, 4'b0, 1'b0, 1'b1});
        wait_idle();
        check("R6", "read data 8001", data_rdata, 32'h0000_8001);
        repeat (8) @(negedge clk);
        check("R8", "no follow-on frame", {31'b0, cmd_rdata[0]}, 32'h0);
        check("R9", "idle mdc", {31'b0, mdc}, 32'h0);

        // R5: write of all ones to address zero.
        wr_reg(1'b1, 32'h0000_FFFF);
        wr_reg(1'b0, cmd(5'h00, 5'h00, 1'b1));
        wait_idle();
        check("R5", "cmd after zero-address write", cmd_rdata, 32'h0000_0002);

        // R6: read of zero overwrites previous ones.
        resp = 16'h0000;
        wr_reg(1'b0, cmd(5'h0A, 5'h15, 1'b0));
        wait_idle();
        check("R6", "read data 0000", data_rdata, 32'h0);

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule